// File: doc/BRIEF.md
# Radix-2 Booth Sequential Signed Multiplier

This block multiplies two signed two's-complement operands over a fixed number of clock cycles. It uses a single adder/subtractor for the whole job. A controller pulses `start` while the block is idle, with the multiplicand and multiplier on their inputs. The block captures both operands and then runs one recoding step per cycle. It raises `done` for one cycle when the full-width signed product is ready on `product`.

Each step looks at two bits: the lowest multiplier bit still in the working register, and the bit that was shifted out just before it. A 1 with a 0 to its right opens a run of ones, and the multiplicand is subtracted from the upper half of the working register. A 0 with a 1 to its right closes a run, and the multiplicand is added. The pairs 0,0 and 1,1 leave the upper half as it is. The whole register then shifts right arithmetically by one place. A run of ones from bit i to bit i+k therefore costs one subtraction weighted 2^i and one addition weighted 2^(i+k+1), instead of k+1 additions.

The upper half is summed one bit wider than the operand. This keeps the result exact when either operand is the most negative value. The interface is plain control and status; there is no data back-pressure. A `start` that arrives while `busy` is high is dropped, and the result stays on `product` until the next accepted `start`.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is low captures both operands, and `busy` reads 1 from the following cycle.
- R3: In each step, the bit pair (current, right) = (1,0) subtracts the multiplicand from the upper half, and (0,1) adds it; this recoding yields the exact product for multipliers made of runs of ones and for alternating bit patterns.
- R4: The pairs (0,0) and (1,1) change nothing before the shift, so a zero multiplier gives a zero product and an all-ones multiplier gives only one subtraction.
- R5: The bit to the right of the multiplier LSB is 0 before the first step, so a multiplier of -1 yields the negated multiplicand.
- R6: Exactly WIDTH steps are performed. `done` is first high on the WIDTH-th rising edge after the edge that accepted `start`, and `busy` falls on that same edge.
- R7: `done` is high for exactly one cycle, and never while `busy` is high.
- R8: `product` equals the signed product of the two operands as a 2*WIDTH-bit two's-complement value, including when either operand or both are the most negative value.
- R9: A `start` sampled while `busy` is high is ignored: the running product and its completion time do not change.
- R10: After `done`, `product` holds its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a multiplication; honoured only when idle |
| mcand | input | WIDTH | Signed multiplicand, sampled on the accepted start |
| mplier | input | WIDTH | Signed multiplier, sampled on the accepted start |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Signed product; held until the next accepted start |

## Verification
The embedded assertions watch the control sequence on every cycle. They check that `done` lasts one cycle and never overlaps `busy`, that `busy` only drops together with `done`, and that a running job cannot be restarted. They also check that an accepted start loads the multiplier with a clear extra bit. Whether the recoding adds and subtracts at the right places, and whether the most negative operands come out exact, shows only in the products the bench compares. The same holds for the exact step count and for an ignored mid-run start leaving the result untouched.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Action chosen for one recoding step
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_PLUS = 2'b01,
    ACT_MINUS = 2'b10
  } booth_act_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic       cur_bit,
  input  logic       right_bit,
  output booth_act_e act
);

  always_comb begin
    unique case ({cur_bit, right_bit})
      2'b10:   act = ACT_MINUS;  // opening a run of ones
      2'b01:   act = ACT_PLUS;   // closing a run of ones
      default: act = ACT_HOLD;   // inside a run of zeros or of ones
    endcase
  end

endmodule

// File: rtl/booth_step_counter.sv
module booth_step_counter #(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  output logic final_step
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (advance) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign final_step = advance && (cnt_q == LAST);

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  booth_act_e         act,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic [2*WIDTH-1:0] acc,
  output logic               low_bit,
  output logic               right_bit
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    acc_q;
  logic             xbit_q;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH:0]   hi_ext, m_ext, hi_sum;
  logic [PW-1:0]    acc_next;

  assign hi_ext = {acc_q[PW-1], acc_q[PW-1:WIDTH]};
  assign m_ext  = {mcand_q[WIDTH-1], mcand_q};

  always_comb begin
    unique case (act)
      ACT_PLUS:  hi_sum = hi_ext + m_ext;
      ACT_MINUS: hi_sum = hi_ext - m_ext;
      default:   hi_sum = hi_ext;
    endcase
    // widened upper half then arithmetic right shift by one
    acc_next = {hi_sum, acc_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      xbit_q  <= 1'b0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= {{WIDTH{1'b0}}, mplier_in};
      xbit_q  <= 1'b0;
      mcand_q <= mcand_in;
    end else if (step) begin
      acc_q  <= acc_next;
      xbit_q <= acc_q[0];
    end
  end

  assign acc       = acc_q;
  assign low_bit   = acc_q[0];
  assign right_bit = xbit_q;

  // R5
  load_clears_xbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (right_bit == 1'b0) && (acc[WIDTH-1:0] == $past(mplier_in)));

  // R10
  idle_holds_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(acc));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  logic       busy_q, done_q;
  logic       accept, last;
  logic       cur_bit, right_bit;
  booth_act_e act;

  assign accept = start && !busy_q;

  booth_recoder u_recoder (
    .cur_bit  (cur_bit),
    .right_bit(right_bit),
    .act      (act)
  );

  booth_step_counter #(.STEPS(WIDTH)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .advance   (busy_q),
    .final_step(last)
  );

  booth_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (busy_q),
    .act      (act),
    .mcand_in (mcand),
    .mplier_in(mplier),
    .acc      (product),
    .low_bit  (cur_bit),
    .right_bit(right_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && last;
      if (accept)    busy_q <= 1'b1;
      else if (last) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R2
  start_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  busy_drop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && !done));

endmodule

// File: tb/test_booth_seq_mult.sv
module test_booth_seq_mult;

  localparam int W = 32;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_seq_mult #(.WIDTH(W)) i_booth_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .busy(busy), .done(done), .product(product)
  );

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    return 64'(sa * sb);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one multiplication; optional ignored start at cycle poke_at
  task automatic run(logic [W-1:0] a, logic [W-1:0] b, int poke_at);
    int cyc = 0;
    logic [2*W-1:0] exp = ref_mul(a, b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mcand = ~a; mplier = b ^ 32'h5A5A_0F0F;
    check("R2 busy after start", 64'(busy), 64'd1);
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (cyc == poke_at) begin
        start = 1'b1;
        @(negedge clk);
        cyc++;
        start = 1'b0;
      end
    end
    check(poke_at > 0 ? "R9 latency with ignored start" : "R6 latency", 64'(cyc), 64'(W));
    check("R6 busy low at done", 64'(busy), 64'd0);
    check(poke_at > 0 ? "R9 product with ignored start" : "R8 product", product, exp);
    @(negedge clk);
    check("R7 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [2*W-1:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 busy reset", 64'(busy), 64'd0);
    check("R1 done reset", 64'(done), 64'd0);
    check("R1 product reset", product, 64'd0);
    rst_n = 1'b1;

    run(32'd12345, 32'd0, 0);                       // R4 zero multiplier
    run(32'd77, 32'hFFFF_FFFF, 0);                  // R5 and R4: -1 multiplier
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);           // R8
    run(32'h8000_0000, 32'h8000_0000, 0);           // R8 most negative squared
    run(32'h8000_0000, 32'hFFFF_FFFF, 0);           // R8
    run(32'h7FFF_FFFF, 32'h8000_0000, 0);           // R8
    run(32'h8000_0000, 32'd1, 0);                   // R8
    run(32'd5, 32'h0000_0F0F, 0);                   // R3 runs of ones
    run(32'hFFFF_FFF3, 32'hAAAA_AAAA, 0);           // R3 alternating
    run(32'd9, 32'h5555_5555, 0);                   // R3 alternating
    run(32'd1234567, 32'h7FFF_FFFF, 0);             // R3 long run
    run(32'hDEAD_BEEF, 32'h1357_9BDF, 5);           // R9 ignored start
    run(32'h0BAD_F00D, 32'hF000_0001, 31);          // R9 late ignored start

    held = product;
    repeat (7) @(negedge clk);
    check("R10 product held", product, held);

    for (int k = 0; k < 60; k++) begin
      logic [W-1:0] a = $urandom();
      logic [W-1:0] b = $urandom();
      if (k % 7 == 0) b = {b[W-1], {(W-1){b[0]}}};
      run(a, b, (k % 5 == 0) ? 3 + (k % 20) : 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule